// File: doc/BRIEF.md
# Two-Rate Three-Colour Token Policer

The block meters a stream of received packets against two token buckets: a committed bucket and a peak bucket. For each packet that arrives it returns a colour (green, yellow or red) and a pass or drop verdict. Each bucket's refill amount and saturation depth is written in a compact floating form. The value `(1+M/256)*2^E` tokens comes from a 5-bit exponent E and an 8-bit mantissa M, and one token is one byte. Bucket levels are held in fixed point with 8 fractional bits, so fractions of a token are exact.

A refill event happens once per policer time unit of `TICK_CYCLES` clocks, multiplied by `2^refill_shift`. At each event both buckets gain their rate and are clipped at their depth. The tokens charged per packet depend on three things: the packet length minus a configurable skip, a signed adjust term that uses the same floating form, and a packet-count mode. In packet-count mode each packet can be made to cost exactly one token. Software places the whole configuration on the `cfg_*` inputs and pulses `cfg_we_i`. That pulse latches the configuration, refills both buckets to their depth and restarts the refill timebase.

Top module: `trtcm_policer`

## Requirements
- R1: Each bucket depth and each refill rate equals `(1+M/256)*2^E` tokens. On `cfg_we_i` both buckets are loaded with their full depth.
- R2: An exponent of 24 or more decodes to zero. A bucket with a zero depth never conforms, so a committed bucket with exponent 24 yields red for every packet in colour-blind single-rate use.
- R3: Refill takes place on the clock edge `K*TICK_CYCLES*2^refill_shift_i` cycles after the configuration write, for K = 1, 2, 3 and so on. Each refill adds the decoded rate to each bucket.
- R4: A bucket level never exceeds its decoded depth. Refill beyond the depth is clipped.
- R5: The cost in 1/256 token units is `max((len_mode ? 0 : len - skip)*256 + (adj_man - 256)*2^adj_exp, 1)`. The cost is therefore at least 1/256 token, even when the byte term is negative.
- R6: With `len_mode_i`=1, `adj_man_i`=384 and `adj_exp_i`=1, every packet costs exactly one token, whatever its length.
- R7: With `meter_mode_i`=2 the colour is decided as follows. A packet is green if the committed bucket covers the cost. It is yellow if only the peak bucket covers the cost. It is red if neither bucket covers it. Cost is debited from every bucket that covered it, and a red packet debits nothing.
- R8: With `meter_mode_i` other than 2, the peak bucket is not consulted and not debited, so packets are only green or red.
- R9: With `color_mode_i`=3 (colour-blind) `pkt_color_i` is ignored. With any other value the incoming colour applies (green=0, yellow=1, red=2). An incoming yellow packet cannot become green, and an incoming red packet stays red.
- R10: Colour codes on `res_color_o` are green=0, yellow=1, red=2. The 2-bit action field for the resulting colour drops the packet when it equals 1 and passes it for any other value.
- R11: `res_valid_o` and the result appear exactly one clock after `pkt_valid_i` is sampled, and `res_valid_o` is low otherwise.
- R12: Configuration inputs take effect only on `cfg_we_i`. After reset all exponents read as 24, the actions are pass and the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the refill timebase |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Latch configuration, fill buckets, restart timebase |
| cir_exp_i | input | 5 | Committed rate exponent |
| cir_man_i | input | 8 | Committed rate mantissa |
| cbs_exp_i | input | 5 | Committed depth exponent |
| cbs_man_i | input | 8 | Committed depth mantissa |
| pir_exp_i | input | 5 | Peak rate exponent |
| pir_man_i | input | 8 | Peak rate mantissa |
| pbs_exp_i | input | 5 | Peak depth exponent |
| pbs_man_i | input | 8 | Peak depth mantissa |
| refill_shift_i | input | 4 | Refill period multiplier as a power of two |
| adj_exp_i | input | 5 | Adjust term exponent |
| adj_man_i | input | 9 | Adjust term mantissa |
| len_mode_i | input | 1 | 1: ignore packet length in the cost |
| len_skip_i | input | 8 | Bytes subtracted from the packet length |
| meter_mode_i | input | 2 | 2: two-rate marking; other values: committed bucket only |
| color_mode_i | input | 2 | 3: colour-blind; other values: colour-aware |
| act_green_i | input | 2 | Action for green (1 = drop) |
| act_yellow_i | input | 2 | Action for yellow (1 = drop) |
| act_red_i | input | 2 | Action for red (1 = drop) |
| pkt_valid_i | input | 1 | Packet present this cycle |
| pkt_len_i | input | LEN_W | Packet length in bytes |
| pkt_color_i | input | 2 | Incoming colour for colour-aware mode |
| res_valid_o | output | 1 | Result valid |
| res_color_o | output | 2 | Resulting colour |
| res_drop_o | output | 1 | 1 = drop the packet |

## Verification
A wrong bucket level shows up at the ports only when a packet probes it. The probe packets are therefore sized so that the cost equals the expected level, or exceeds it by one token or by 1/256 of a token. One probe then tells a correct level apart from one that is off by a single unit. Refill timing errors are caught within one refill period: a probe is placed just before the expected refill edge and another just after it. A colour or action mix-up is caught on the very next result.

// File: rtl/trtcm_pkg.sv
package trtcm_pkg;
  localparam int EXP_W  = 5;
  localparam int MAN_W  = 8;
  localparam int FIX_W  = 32;  // (511 << 23) fits
  localparam int COST_W = 48;
  localparam int EXP_OFF = 24;

  typedef enum logic [1:0] {
    CLR_GREEN  = 2'd0,
    CLR_YELLOW = 2'd1,
    CLR_RED    = 2'd2
  } color_e;

  localparam logic [1:0] ACT_DROP   = 2'd1;
  localparam logic [1:0] MODE_2RATE = 2'd2;
  localparam logic [1:0] MODE_BLIND = 2'd3;

  typedef struct packed {
    logic [EXP_W-1:0] cir_e;
    logic [MAN_W-1:0] cir_m;
    logic [EXP_W-1:0] cbs_e;
    logic [MAN_W-1:0] cbs_m;
    logic [EXP_W-1:0] pir_e;
    logic [MAN_W-1:0] pir_m;
    logic [EXP_W-1:0] pbs_e;
    logic [MAN_W-1:0] pbs_m;
    logic [3:0]       shift;
    logic [4:0]       adj_e;
    logic [8:0]       adj_m;
    logic             len_mode;
    logic [7:0]       len_skip;
    logic [1:0]       meter;
    logic [1:0]       cmode;
    logic [1:0]       act_g;
    logic [1:0]       act_y;
    logic [1:0]       act_r;
  } cfg_t;

  // (1+m/256)*2^e tokens, in 1/256-token units
  function automatic logic [FIX_W-1:0] fp_decode(logic [EXP_W-1:0] e, logic [MAN_W-1:0] m);
    if (int'(e) >= EXP_OFF) return '0;
    return FIX_W'({1'b1, m}) << e;
  endfunction
endpackage

// File: rtl/trtcm_timebase.sv
module trtcm_timebase #(
  parameter int TICK_CYCLES = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic [3:0] shift_i,
  output logic       refill_o
);
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      div_q;
  logic [15:0]      div_last;
  logic             tick;

  assign div_last = ~(16'hFFFF << shift_i);
  assign tick     = (cnt_q == CNT_LAST);
  assign refill_o = tick && (div_q == div_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) div_q <= (div_q >= div_last) ? '0 : div_q + 1'b1;
    end
  end

  generate
    if (TICK_CYCLES > 1) begin : g_chk
      AST_REFILL_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refill_o |=> !refill_o); // R3
    end
  endgenerate
endmodule

// File: rtl/trtcm_cost.sv
module trtcm_cost import trtcm_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic              len_mode_i,
  input  logic [7:0]        len_skip_i,
  input  logic [4:0]        adj_e_i,
  input  logic [8:0]        adj_m_i,
  output logic [COST_W-1:0] cost_o
);
  logic signed [COST_W-1:0] diff, base, adj, sum;

  always_comb begin
    diff   = $signed(COST_W'(len_i)) - $signed(COST_W'(len_skip_i));
    base   = len_mode_i ? '0 : (diff <<< 8);
    adj    = ($signed(COST_W'(adj_m_i)) - $signed(COST_W'(256))) <<< adj_e_i;
    sum    = base + adj;
    cost_o = (sum < $signed(COST_W'(1))) ? COST_W'(1) : $unsigned(sum);
  end
endmodule

// File: rtl/trtcm_bucket.sv
module trtcm_bucket import trtcm_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FIX_W-1:0]  load_cap_i,
  input  logic [FIX_W-1:0]  cap_i,
  input  logic [FIX_W-1:0]  rate_i,
  input  logic              refill_i,
  input  logic              debit_i,
  input  logic [COST_W-1:0] cost_i,
  output logic              conform_o
);
  logic [FIX_W-1:0] lvl_q, lvl_d, after_debit;
  logic [FIX_W:0]   sum;

  assign conform_o = ({{(COST_W-FIX_W){1'b0}}, lvl_q} >= cost_i);

  always_comb begin
    after_debit = lvl_q - (debit_i ? cost_i[FIX_W-1:0] : '0);
    sum         = {1'b0, after_debit} + {1'b0, (refill_i ? rate_i : '0)};
    lvl_d       = (sum > {1'b0, cap_i}) ? cap_i : sum[FIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= '0;
    else if (load_i) lvl_q <= load_cap_i;
    else             lvl_q <= lvl_d;
  end

  AST_LVL_LE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= cap_i); // R4
  AST_DEBIT_CONFORMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debit_i |-> conform_o); // R7
endmodule

// File: rtl/trtcm_policer.sv
module trtcm_policer import trtcm_pkg::*; #(
  parameter int LEN_W       = 16,
  parameter int TICK_CYCLES = 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [4:0]       cir_exp_i,
  input  logic [7:0]       cir_man_i,
  input  logic [4:0]       cbs_exp_i,
  input  logic [7:0]       cbs_man_i,
  input  logic [4:0]       pir_exp_i,
  input  logic [7:0]       pir_man_i,
  input  logic [4:0]       pbs_exp_i,
  input  logic [7:0]       pbs_man_i,
  input  logic [3:0]       refill_shift_i,
  input  logic [4:0]       adj_exp_i,
  input  logic [8:0]       adj_man_i,
  input  logic             len_mode_i,
  input  logic [7:0]       len_skip_i,
  input  logic [1:0]       meter_mode_i,
  input  logic [1:0]       color_mode_i,
  input  logic [1:0]       act_green_i,
  input  logic [1:0]       act_yellow_i,
  input  logic [1:0]       act_red_i,
  input  logic             pkt_valid_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [1:0]       pkt_color_i,
  output logic             res_valid_o,
  output logic [1:0]       res_color_o,
  output logic             res_drop_o
);
  localparam int NB = 2;  // 0: committed, 1: peak

  cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = '{cir_e: cir_exp_i, cir_m: cir_man_i, cbs_e: cbs_exp_i, cbs_m: cbs_man_i,
              pir_e: pir_exp_i, pir_m: pir_man_i, pbs_e: pbs_exp_i, pbs_m: pbs_man_i,
              shift: refill_shift_i, adj_e: adj_exp_i, adj_m: adj_man_i,
              len_mode: len_mode_i, len_skip: len_skip_i, meter: meter_mode_i,
              cmode: color_mode_i, act_g: act_green_i, act_y: act_yellow_i,
              act_r: act_red_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      cfg_q.cir_e <= EXP_W'(EXP_OFF);
      cfg_q.cbs_e <= EXP_W'(EXP_OFF);
      cfg_q.pir_e <= EXP_W'(EXP_OFF);
      cfg_q.pbs_e <= EXP_W'(EXP_OFF);
    end else if (cfg_we_i) begin
      cfg_q <= cfg_d;
    end
  end

  logic refill;
  trtcm_timebase #(.TICK_CYCLES(TICK_CYCLES)) u_tb (
    .clk_i, .rst_ni, .clear_i(cfg_we_i), .shift_i(cfg_q.shift), .refill_o(refill)
  );

  logic [COST_W-1:0] cost;
  trtcm_cost #(.LEN_W(LEN_W)) u_cost (
    .len_i(pkt_len_i), .len_mode_i(cfg_q.len_mode), .len_skip_i(cfg_q.len_skip),
    .adj_e_i(cfg_q.adj_e), .adj_m_i(cfg_q.adj_m), .cost_o(cost)
  );

  logic [FIX_W-1:0] cap_now [NB];
  logic [FIX_W-1:0] cap_new [NB];
  logic [FIX_W-1:0] rate    [NB];
  logic             debit   [NB];
  logic             conform [NB];

  assign cap_now[0] = fp_decode(cfg_q.cbs_e, cfg_q.cbs_m);
  assign cap_now[1] = fp_decode(cfg_q.pbs_e, cfg_q.pbs_m);
  assign cap_new[0] = fp_decode(cfg_d.cbs_e, cfg_d.cbs_m);
  assign cap_new[1] = fp_decode(cfg_d.pbs_e, cfg_d.pbs_m);
  assign rate[0]    = fp_decode(cfg_q.cir_e, cfg_q.cir_m);
  assign rate[1]    = fp_decode(cfg_q.pir_e, cfg_q.pir_m);

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    trtcm_bucket u_bkt (
      .clk_i, .rst_ni, .load_i(cfg_we_i), .load_cap_i(cap_new[b]), .cap_i(cap_now[b]),
      .rate_i(rate[b]), .refill_i(refill), .debit_i(debit[b]), .cost_i(cost),
      .conform_o(conform[b])
    );
  end

  logic   blind, use_peak, c_ok, p_ok;
  color_e color;
  logic [1:0] act;

  always_comb begin
    blind    = (cfg_q.cmode == MODE_BLIND);
    use_peak = (cfg_q.meter == MODE_2RATE);
    c_ok     = conform[0] && (blind || pkt_color_i == CLR_GREEN);
    p_ok     = use_peak && conform[1] && (blind || pkt_color_i != CLR_RED);
    if (c_ok)      color = CLR_GREEN;
    else if (p_ok) color = CLR_YELLOW;
    else           color = CLR_RED;
    debit[0] = pkt_valid_i && c_ok;
    debit[1] = pkt_valid_i && p_ok;
    case (color)
      CLR_GREEN:  act = cfg_q.act_g;
      CLR_YELLOW: act = cfg_q.act_y;
      default:    act = cfg_q.act_r;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_color_o <= 2'd0;
      res_drop_o  <= 1'b0;
    end else begin
      res_valid_o <= pkt_valid_i;
      if (pkt_valid_i) begin
        res_color_o <= color;
        res_drop_o  <= (act == ACT_DROP);
      end
    end
  end

  AST_RES_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> res_valid_o); // R11
  AST_RES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> !res_valid_o); // R11
  AST_NO_YELLOW_1RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && cfg_q.meter != MODE_2RATE) |=> res_color_o != CLR_YELLOW); // R8
  AST_AWARE_RED_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && cfg_q.cmode != MODE_BLIND && pkt_color_i == CLR_RED)
      |=> res_color_o == CLR_RED); // R9
endmodule

// File: tb/trtcm_policer_tb.sv
module trtcm_policer_tb;
  localparam int TICK = 4;
  localparam logic [1:0] G = 2'd0, Y = 2'd1, RD = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_we = 0;
  logic [4:0] cir_e, cbs_e, pir_e, pbs_e, adj_e;
  logic [7:0] cir_m, cbs_m, pir_m, pbs_m, skip;
  logic [3:0] shift;
  logic [8:0] adj_m;
  logic lmode;
  logic [1:0] meter, cmode, act_g, act_y, act_r;
  logic pkt_valid = 0;
  logic [15:0] pkt_len = 0;
  logic [1:0] pkt_col = 0;
  logic res_valid, res_drop;
  logic [1:0] res_col;

  int checks = 0, failures = 0;

  trtcm_policer #(.LEN_W(16), .TICK_CYCLES(TICK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we),
    .cir_exp_i(cir_e), .cir_man_i(cir_m), .cbs_exp_i(cbs_e), .cbs_man_i(cbs_m),
    .pir_exp_i(pir_e), .pir_man_i(pir_m), .pbs_exp_i(pbs_e), .pbs_man_i(pbs_m),
    .refill_shift_i(shift), .adj_exp_i(adj_e), .adj_man_i(adj_m),
    .len_mode_i(lmode), .len_skip_i(skip), .meter_mode_i(meter), .color_mode_i(cmode),
    .act_green_i(act_g), .act_yellow_i(act_y), .act_red_i(act_r),
    .pkt_valid_i(pkt_valid), .pkt_len_i(pkt_len), .pkt_color_i(pkt_col),
    .res_valid_o(res_valid), .res_color_o(res_col), .res_drop_o(res_drop));

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual={v,col,drop}=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic defaults();
    cir_e = 24; cir_m = 0; cbs_e = 24; cbs_m = 0;
    pir_e = 24; pir_m = 0; pbs_e = 24; pbs_m = 0;
    shift = 0; adj_e = 0; adj_m = 256; lmode = 0; skip = 0;
    meter = 2; cmode = 3; act_g = 0; act_y = 0; act_r = 1;
  endtask

  task automatic write_cfg();
    cfg_we = 1; @(negedge clk); cfg_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one packet; result read one clock later
  task automatic send(input string req, input logic [15:0] len, input logic [1:0] col,
                      input logic [1:0] exp_col, input logic exp_drop);
    pkt_valid = 1; pkt_len = len; pkt_col = col;
    @(negedge clk);
    pkt_valid = 0;
    check(req, {res_valid, res_col, res_drop}, {1'b1, exp_col, exp_drop});
  endtask

  task automatic t_reset();
    check("R12 reset outputs", {res_valid, res_col, res_drop}, 4'b0000);
    idle(1);
    check("R11 no result when idle", {res_valid, res_col, res_drop}, 4'b0000);
    send("R12 reset buckets disabled, pass", 16'd0, G, RD, 1'b0);
  endtask

  task automatic t_depth_mantissa();
    defaults(); cbs_e = 5; cbs_m = 128; meter = 0; write_cfg();  // 48 tokens
    send("R1 full 1.5*32 depth", 16'd48, G, G, 1'b0);
    send("R1 empty after drain", 16'd1, G, RD, 1'b1);
  endtask

  task automatic t_disabled();
    defaults(); cbs_e = 24; cbs_m = 0; meter = 0; write_cfg();
    send("R2 exp 24 zero depth", 16'd0, G, RD, 1'b1);
  endtask

  task automatic t_refill_shift();
    defaults(); cbs_e = 4; cir_e = 4; shift = 2; meter = 0; write_cfg();  // period 16
    send("R3 drain", 16'd16, G, G, 1'b0);
    idle(7);
    send("R3 before refill edge", 16'd16, G, RD, 1'b1);
    idle(7);
    send("R3 after refill edge", 16'd16, G, G, 1'b0);
  endtask

  task automatic t_saturate();
    defaults(); cbs_e = 5; cir_e = 4; shift = 1; meter = 0; write_cfg();  // period 8
    send("R4 drain", 16'd32, G, G, 1'b0);
    idle(30);
    send("R4 clipped at depth", 16'd33, G, RD, 1'b1);
    send("R4 depth available", 16'd32, G, G, 1'b0);
  endtask

  task automatic t_cost();
    defaults(); cbs_e = 0; meter = 0; skip = 10; write_cfg();  // 1 token
    send("R5 negative byte term costs 1/256", 16'd5, G, G, 1'b0);
    send("R5 255/256 left, one token red", 16'd11, G, RD, 1'b1);
    defaults(); cbs_e = 4; meter = 0; skip = 10; adj_m = 128; adj_e = 3; write_cfg();
    send("R5 len-skip-4 = 16", 16'd30, G, G, 1'b0);
    send("R5 bucket empty", 16'd15, G, RD, 1'b1);
  endtask

  task automatic t_pps();
    defaults(); cbs_e = 1; meter = 0; lmode = 1; adj_m = 384; adj_e = 1; write_cfg();
    send("R6 pkt 1 of 2", 16'd1500, G, G, 1'b0);
    send("R6 pkt 2 of 2", 16'd9000, G, G, 1'b0);
    send("R6 pkt 3 exceeds", 16'd1, G, RD, 1'b1);
  endtask

  task automatic t_two_rate();
    defaults(); cbs_e = 4; pbs_e = 5; act_y = 1; act_r = 0; write_cfg();
    send("R7 green", 16'd16, G, G, 1'b0);
    send("R7 yellow, peak debited by green", 16'd16, G, Y, 1'b1);
    send("R7 red", 16'd1, G, RD, 1'b0);
  endtask

  task automatic t_one_rate();
    defaults(); cbs_e = 4; pbs_e = 5; meter = 0; act_y = 1; write_cfg();
    send("R8 green", 16'd16, G, G, 1'b0);
    send("R8 red, peak not used", 16'd16, G, RD, 1'b1);
  endtask

  task automatic t_aware();
    defaults(); cbs_e = 4; pbs_e = 5; cmode = 0; write_cfg();
    send("R9 aware yellow stays yellow", 16'd16, Y, Y, 1'b0);
    send("R9 aware red stays red", 16'd1, RD, RD, 1'b1);
    send("R9 aware green, committed full", 16'd16, G, G, 1'b0);
    defaults(); cbs_e = 4; cmode = 3; write_cfg();
    send("R9 blind ignores red input", 16'd16, RD, G, 1'b0);
  endtask

  task automatic t_actions();
    defaults(); cbs_e = 4; act_g = 1; act_r = 2; write_cfg();
    send("R10 green action drop", 16'd16, G, G, 1'b1);
    send("R10 action code 2 passes", 16'd16, G, RD, 1'b0);
  endtask

  task automatic t_latch();
    defaults(); write_cfg();
    act_r = 0; cbs_e = 10; meter = 0;
    send("R12 unwritten inputs no effect", 16'd1, G, RD, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    defaults();
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_depth_mantissa();
    t_disabled();
    t_refill_shift();
    t_saturate();
    t_cost();
    t_pps();
    t_two_rate();
    t_one_rate();
    t_aware();
    t_actions();
    t_latch();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule